// File: doc/BRIEF.md
# 64-bit Compare Timer

This block is a memory-mapped timer for a small processor system. A 64-bit counter runs while the block is enabled. It advances by a programmable increment once every (divider + 1) clock cycles. A 64-bit compare value is checked against the counter. When the counter reaches or passes the compare value, a raw machine-timer output rises. If the interrupt enable is set, the same condition also latches a status bit that drives a maskable interrupt line.

Software reaches the block through a simple 32-bit register port: valid, write, a byte address within a 1 KB window, write data and read data. Only aligned 32-bit accesses are used. Read data is registered and appears on the cycle after the request.

The register offsets are given in bytes:
- 0x000: alert test, write-only, has no effect.
- 0x004: control. Bit 0 is the enable.
- 0x100: configuration. Bits 11:0 hold the divider and bits 23:16 hold the increment.
- 0x104 / 0x108: counter low / high halves.
- 0x10C / 0x110: compare low / high halves.
- 0x114: interrupt enable, bit 0.
- 0x118: interrupt status, bit 0.
- 0x11C: interrupt test, write-only.

Top module: `cmp_timer`

## Requirements
- R1: After reset these registers read as follows: control 0, configuration 0x0001_0000 (increment 1, divider 0), both compare halves 0xFFFF_FFFF, interrupt enable 0, interrupt status 0. Both outputs are low.
- R2: While control bit 0 is clear, the counter holds its value.
- R3: While control bit 0 is set, the counter increases by the increment once every (divider + 1) cycles. The low half is at 0x104 and the high half is at 0x108.
- R4: Writes to the counter halves have no effect on the counter.
- R5: Reads of the alert test register, the interrupt test register and any unmapped offset return zero.
- R6: While enabled, a compare value less than or equal to the counter drives the machine-timer output high, whatever the interrupt enable holds.
- R7: While control bit 0 is clear, the machine-timer output holds its value, and no match sets the status bit.
- R8: A match with interrupt enable bit 0 set sets status bit 0 and raises the interrupt line.
- R9: While enabled, a compare write clears status bit 0. A compare value greater than the counter lowers both outputs within two cycles.
- R10: Writing a 1 to status bit 0 clears it. Writing a 0 leaves it unchanged.
- R11: A write to the interrupt test register sets status bit 0 only when written bit 0 and enable bit 0 are both 1.
- R12: The interrupt line equals status bit 0 AND enable bit 0. Clearing the enable lowers the line but keeps the status.
- R13: Read data is valid on the cycle after a read request and is zero in every other cycle.
- R14: Control, enable and configuration read back the bits that were written. Configuration keeps only bits 23:16 and 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| mach_timer_o | output | 1 | Raw compare-match output |
| irq_o | output | 1 | Maskable interrupt line |

## Verification
Timing of each result, counting from the clock edge that accepts an access:
- A register write takes effect at that edge.
- Read data appears after that edge, so the bench samples it on the following falling edge.
- The match is evaluated one edge later, against the registered compare and counter values. The machine-timer output and status bit therefore change one cycle after their operands change. The bench waits at least two cycles before it samples them.
- The interrupt line is a gate of two flops and follows status or enable in the same cycle they change.

Counter rate checks do not predict the absolute count. They compare two reads taken a known number of edges apart, so the divider phase cannot affect the expected value.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ALERT  = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h100;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h104;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h108;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 10'h10C;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 10'h110;
  localparam logic [ADDR_W-1:0] OFS_IE     = 10'h114;
  localparam logic [ADDR_W-1:0] OFS_STATE  = 10'h118;
  localparam logic [ADDR_W-1:0] OFS_TEST   = 10'h11C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_CFG, SEL_CNT_LO, SEL_CNT_HI,
    SEL_CMP_LO, SEL_CMP_HI, SEL_IE, SEL_STATE, SEL_TEST
  } reg_sel_e;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8,
  localparam int CNT_W = 2*DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              status,
  output logic              active,
  output logic [PRE_W-1:0]  prescale,
  output logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cmp,
  output logic              ie,
  output logic              cmp_wr,
  output logic              clr_req,
  output logic              test_req
);
  localparam int STEP_LSB = 16;

  reg_sel_e sel;
  logic     wr, rd;

  always_comb begin
    unique case (bus_addr[ADDR_W-1:2])
      OFS_CTRL[ADDR_W-1:2]:   sel = SEL_CTRL;
      OFS_CFG[ADDR_W-1:2]:    sel = SEL_CFG;
      OFS_CNT_LO[ADDR_W-1:2]: sel = SEL_CNT_LO;
      OFS_CNT_HI[ADDR_W-1:2]: sel = SEL_CNT_HI;
      OFS_CMP_LO[ADDR_W-1:2]: sel = SEL_CMP_LO;
      OFS_CMP_HI[ADDR_W-1:2]: sel = SEL_CMP_HI;
      OFS_IE[ADDR_W-1:2]:     sel = SEL_IE;
      OFS_STATE[ADDR_W-1:2]:  sel = SEL_STATE;
      OFS_TEST[ADDR_W-1:2]:   sel = SEL_TEST;
      default:                sel = SEL_NONE;
    endcase
  end

  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign cmp_wr   = wr && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);
  assign clr_req  = wr && (sel == SEL_STATE) && bus_wdata[0];
  assign test_req = wr && (sel == SEL_TEST) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      prescale <= '0;
      step     <= STEP_W'(1);
      cmp      <= '1;
      ie       <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL:   active <= bus_wdata[0];
        SEL_CFG: begin
          prescale <= bus_wdata[PRE_W-1:0];
          step     <= bus_wdata[STEP_LSB +: STEP_W];
        end
        SEL_CMP_LO: cmp[DATA_W-1:0]     <= bus_wdata;
        SEL_CMP_HI: cmp[CNT_W-1:DATA_W] <= bus_wdata;
        SEL_IE:     ie <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:   rd_mux[0] = active;
      SEL_CFG: begin
        rd_mux[PRE_W-1:0]          = prescale;
        rd_mux[STEP_LSB +: STEP_W] = step;
      end
      SEL_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      SEL_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
      SEL_CMP_LO: rd_mux = cmp[DATA_W-1:0];
      SEL_CMP_HI: rd_mux = cmp[CNT_W-1:DATA_W];
      SEL_IE:     rd_mux[0] = ie;
      SEL_STATE:  rd_mux[0] = status;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !rd) bus_rdata <= '0;
    else            bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int CNT_W  = 64,
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cnt
);
  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q >= prescale);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt   <= '0;
    end else if (active) begin
      if (wrap) begin
        pre_q <= '0;
        cnt   <= cnt + CNT_W'(step);
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ie,
  input  logic             cmp_wr,
  input  logic             clr_req,
  input  logic             test_req,
  output logic             mach,
  output logic             status,
  output logic             irq
);
  logic hit, set_hit, set_test, clr;

  assign hit      = (cmp <= cnt);
  assign set_hit  = active && hit && ie && !cmp_wr;
  assign set_test = test_req && ie;
  assign clr      = clr_req || (cmp_wr && active);

  always_ff @(posedge clk) begin
    if (rst) begin
      mach   <= 1'b0;
      status <= 1'b0;
    end else begin
      if (active) mach <= hit;
      status <= (status && !clr) || set_hit || set_test;
    end
  end

  assign irq = status && ie;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mach_timer_o,
  output logic              irq_o
);
  localparam int CNT_W = 2*DATA_W;

  logic              active_w, ie_w, status_w;
  logic              cmp_wr_w, clr_w, test_w;
  logic [PRE_W-1:0]  pre_w;
  logic [STEP_W-1:0] step_w;
  logic [CNT_W-1:0]  cnt_w, cmp_w;

  cmp_timer_regs #(.PRE_W(PRE_W), .STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_w), .status(status_w), .active(active_w), .prescale(pre_w),
    .step(step_w), .cmp(cmp_w), .ie(ie_w), .cmp_wr(cmp_wr_w),
    .clr_req(clr_w), .test_req(test_w)
  );

  cmp_timer_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .STEP_W(STEP_W)) u_count (
    .clk(clk), .rst(rst), .active(active_w), .prescale(pre_w),
    .step(step_w), .cnt(cnt_w)
  );

  cmp_timer_irq #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .active(active_w), .cnt(cnt_w), .cmp(cmp_w),
    .ie(ie_w), .cmp_wr(cmp_wr_w), .clr_req(clr_w), .test_req(test_w),
    .mach(mach_timer_o), .status(status_w), .irq(irq_o)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [31:0]      bus_rdata,
  input logic             mach_timer_o,
  input logic             active,
  input logic             ie,
  input logic             status,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp
);
  AST_CNT_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cnt)); // R2

  AST_MACH_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(mach_timer_o)); // R7

  AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (rst)
    (active && (cmp <= cnt)) |=> mach_timer_o); // R6

  AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(ie)); // R8

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> (bus_rdata == '0)); // R13
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(2*cmp_timer_pkg::DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rdata(bus_rdata), .mach_timer_o(mach_timer_o), .active(active_w),
  .ie(ie_w), .status(status_w), .cnt(cnt_w), .cmp(cmp_w)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mach_timer_o, irq_o;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        track = 1'b0, rd_seen = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mach_timer_o(mach_timer_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each tracked read
  always @(posedge clk) rd_seen <= bus_valid && !bus_write && track;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("SCOREBOARD underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // all tasks start and end at a falling edge; one access = one edge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_exp(input logic [9:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    track = 1; bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; track = 0;
  endtask

  task automatic rd_val(input logic [9:0] a, output logic [31:0] v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    idle(3); rst = 0; idle(1);

    // R1 reset state
    chk("R1 mach", {31'b0, mach_timer_o}, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd_exp(10'h004, 32'h0, "R1 control");
    rd_exp(10'h100, 32'h0001_0000, "R1 config");
    rd_exp(10'h10C, 32'hFFFF_FFFF, "R1 compare low");
    rd_exp(10'h110, 32'hFFFF_FFFF, "R1 compare high");
    rd_exp(10'h114, 32'h0, "R1 enable");
    rd_exp(10'h118, 32'h0, "R1 status");

    // R2 counter holds while disabled
    rd_exp(10'h104, 32'h0, "R2 count before");
    idle(10);
    rd_exp(10'h104, 32'h0, "R2 count after");

    // R5 write-only and unmapped reads
    rd_exp(10'h000, 32'h0, "R5 alert test");
    rd_exp(10'h11C, 32'h0, "R5 interrupt test");
    rd_exp(10'h200, 32'h0, "R5 unmapped");
    // R13 read data returns to zero
    idle(1);
    chk("R13 idle rdata", bus_rdata, 0);

    // R7 disabled: compare in the past does not raise anything
    wr(10'h10C, 0); wr(10'h110, 0); wr(10'h114, 1);
    idle(4);
    chk("R7 mach stays low", {31'b0, mach_timer_o}, 0);
    rd_exp(10'h118, 32'h0, "R7 status stays clear");
    wr(10'h114, 0);

    // R14 readback with config field masking
    wr(10'h100, 32'hFFFF_FFFF);
    rd_exp(10'h100, 32'h00FF_0FFF, "R14 config mask");
    wr(10'h100, 32'h0001_0000);
    wr(10'h114, 32'hFFFF_FFFF);
    rd_exp(10'h114, 32'h1, "R14 enable");
    wr(10'h114, 0);

    // R6 enable; match raises raw output without the interrupt
    wr(10'h004, 1);
    rd_exp(10'h004, 32'h1, "R14 control");
    idle(3);
    chk("R6 mach high", {31'b0, mach_timer_o}, 1);
    chk("R6 irq low", {31'b0, irq_o}, 0);
    rd_exp(10'h118, 32'h0, "R6 status clear with enable off");

    // R3 rate: divider 0 increment 1, reads 5 edges apart
    rd_val(10'h104, a); idle(4); rd_val(10'h104, b);
    chk("R3 delta div0 inc1", b - a, 5);
    wr(10'h100, 32'h0005_0003);
    rd_val(10'h104, a); idle(7); rd_val(10'h104, b);
    chk("R3 delta div3 inc5", b - a, 10);
    rd_val(10'h104, a); idle(15); rd_val(10'h104, b);
    chk("R3 delta div3 inc5 long", b - a, 20);
    rd_exp(10'h108, 32'h0, "R3 count high");

    // R8 enable interrupt with a live match
    wr(10'h114, 1);
    idle(2);
    chk("R8 irq high", {31'b0, irq_o}, 1);
    rd_exp(10'h118, 32'h1, "R8 status set");

    // R9 compare moved to the future
    wr(10'h110, 1);
    idle(2);
    chk("R9 mach low", {31'b0, mach_timer_o}, 0);
    chk("R9 irq low", {31'b0, irq_o}, 0);
    rd_exp(10'h118, 32'h0, "R9 status cleared");

    // R10 write-1-to-clear
    wr(10'h11C, 1);
    rd_exp(10'h118, 32'h1, "R11 test sets status");
    wr(10'h118, 0);
    rd_exp(10'h118, 32'h1, "R10 zero write keeps status");
    wr(10'h118, 1);
    rd_exp(10'h118, 32'h0, "R10 one write clears");
    chk("R10 irq low", {31'b0, irq_o}, 0);

    // R11 test gating
    wr(10'h11C, 0);
    rd_exp(10'h118, 32'h0, "R11 zero test write");
    wr(10'h114, 0);
    wr(10'h11C, 1);
    rd_exp(10'h118, 32'h0, "R11 test blocked by enable");
    chk("R11 irq low", {31'b0, irq_o}, 0);

    // R12 line = status AND enable
    wr(10'h114, 1); wr(10'h11C, 1);
    chk("R12 irq high", {31'b0, irq_o}, 1);
    wr(10'h114, 0);
    chk("R12 irq masked", {31'b0, irq_o}, 0);
    rd_exp(10'h118, 32'h1, "R12 status kept");
    wr(10'h114, 1);
    chk("R12 irq back", {31'b0, irq_o}, 1);
    wr(10'h118, 1);

    // R4 counter writes ignored
    wr(10'h004, 0);
    rd_val(10'h104, a);
    wr(10'h104, 32'h1234_5678); wr(10'h108, 32'hABCD);
    rd_exp(10'h104, a, "R4 count low unchanged");
    rd_exp(10'h108, 32'h0, "R4 count high unchanged");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule